// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Command Sequencer

This block brings a single-rank SDR SDRAM out of power-up and then keeps it refreshed. After a start pulse it raises the clock-enable pin and waits a programmable settling time. It then closes every bank with a precharge and issues a burst of auto-refresh commands. Last, it loads the mode register with a burst length of 2, sequential ordering, a CAS latency of 3 and single-location writes. Every gap between commands is a parameter in controller clock cycles.

Once the mode load has settled, the block reports ready. From then on a countdown timer requests one auto-refresh each time it runs out, and the timer is reloaded on every refresh. A read/write controller placed beside this block reads `busy` to know when the command pins belong to the sequencer. The default geometry is 4 banks, 12 row address bits and a 16-bit data bus, which gives two byte masks.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, and after it until start: CKE is low, the command pins {csN,rasN,casN,weN} read NOP 4'b0111, cmdStrobe, busy and ready are low, the bank address is zero and every byte mask is high.
- R2: The first start pulse after reset raises busy on the next cycle and raises CKE one cycle after that. CKE then stays high until reset, and no command is strobed while CKE is low.
- R3: Precharge-all (4'b0010 with address bit 10 high) appears on the pins PWRUP_CYCLES+1 cycles after CKE rises.
- R4: Exactly INIT_REFRESHES (default 4) auto-refresh commands (4'b0001) follow. The first comes T_RP cycles after the precharge, and each later one comes T_RC cycles after the one before.
- R5: Load-mode (4'b0000) follows T_RC cycles after the last initial refresh. Its address word is 12'h231: bits [2:0]=001, bit 3=0, bits [6:4]=011, bit 9=1, all other bits 0.
- R6: cmdStrobe is high in exactly the cycles that carry a non-NOP command, and every other cycle carries NOP.
- R7: ready first reads high T_MRD-1 cycles after the cycle in which load-mode is on the pins, and busy falls in that same cycle. ready then stays high until reset.
- R8: The first periodic auto-refresh appears REFRESH_RELOAD+T_MRD+1 cycles after load-mode. Each later periodic refresh appears REFRESH_RELOAD+2 cycles after the one before.
- R9: busy is high in the cycle of each periodic refresh and for the T_RC-2 cycles after it, then low.
- R10: A start pulse given while the sequence is running, or after ready, has no effect on the command stream or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins the power-up sequence |
| busy | output | 1 | Sequencer owns the command pins |
| ready | output | 1 | Initialization complete |
| cmdStrobe | output | 1 | A non-NOP command is on the pins this cycle |
| sdCke | output | 1 | SDRAM clock enable |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdBa | output | BANK_BITS | Bank address |
| sdAddr | output | ROW_BITS | Row/column/mode address |
| sdDqm | output | DQM_W | Byte masks |

## Verification
The checker assumes `start` is synchronous to `clk` and that reset is held for at least one edge before release. It also assumes the parameters meet the sequencer's needs: every timing gap is at least 2 cycles, and the refresh reload exceeds T_RC. The bench uses the default timings and drives `start` only at falling edges. It pulses `start` again in the middle of the sequence, so the R10 property is exercised within those assumptions.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // Command code on {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_MODE = 4'b0000,
    CMD_REF  = 4'b0001,
    CMD_PRE  = 4'b0010,
    CMD_NOP  = 4'b0111
  } sdCmd_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic ckeOn;
    logic issuePre;
    logic issueRef;
    logic issueMode;
    logic loadRefresh;
  } seqStrobe_t;

  function automatic int maxOf4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int REFRESH_RELOAD = 683
) (
  input  logic clk,
  input  logic rstN,
  input  logic load,
  output logic due
);
  localparam int CNT_W = $clog2(REFRESH_RELOAD + 1);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (load) begin
      count <= CNT_W'(REFRESH_RELOAD);
    end else if (count != '0) begin
      count <= count - 1'b1;
    end
  end

  assign due = (count == '0);
endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int PWRUP_CYCLES   = 100,
  parameter int T_RP           = 2,
  parameter int T_RC           = 7,
  parameter int T_MRD          = 2,
  parameter int INIT_REFRESHES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       refDue,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       ready
);
  localparam int TMAX    = maxOf4(PWRUP_CYCLES, T_RP, T_RC, T_MRD);
  localparam int TIMER_W = $clog2(TMAX + 1);
  localparam int REFC_W  = $clog2(INIT_REFRESHES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CKE, S_PWRUP, S_PRE, S_WRP, S_REF, S_WRC,
    S_MODE, S_WMRD, S_READY, S_AUTOREF, S_WRUN
  } seqState_e;

  seqState_e          state;
  logic [TIMER_W-1:0] timer;
  logic [REFC_W-1:0]  refLeft;
  logic               timerLast;

  assign timerLast = (timer == TIMER_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      timer   <= '0;
      refLeft <= '0;
    end else begin
      case (state)
        S_IDLE:  if (start) state <= S_CKE;
        S_CKE: begin
          timer <= TIMER_W'(PWRUP_CYCLES);
          state <= S_PWRUP;
        end
        S_PWRUP: begin
          if (timerLast) state <= S_PRE;
          else timer <= timer - 1'b1;
        end
        S_PRE: begin
          timer   <= TIMER_W'(T_RP - 1);
          refLeft <= REFC_W'(INIT_REFRESHES);
          state   <= S_WRP;
        end
        S_WRP: begin
          if (timerLast) state <= S_REF;
          else timer <= timer - 1'b1;
        end
        S_REF: begin
          timer   <= TIMER_W'(T_RC - 1);
          refLeft <= refLeft - 1'b1;
          state   <= S_WRC;
        end
        S_WRC: begin
          if (timerLast) state <= (refLeft == '0) ? S_MODE : S_REF;
          else timer <= timer - 1'b1;
        end
        S_MODE: begin
          timer <= TIMER_W'(T_MRD - 1);
          state <= S_WMRD;
        end
        S_WMRD: begin
          if (timerLast) state <= S_READY;
          else timer <= timer - 1'b1;
        end
        S_READY: if (refDue) state <= S_AUTOREF;
        S_AUTOREF: begin
          timer <= TIMER_W'(T_RC - 1);
          state <= S_WRUN;
        end
        S_WRUN: begin
          if (timerLast) state <= S_READY;
          else timer <= timer - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe             = '0;
    strobe.ckeOn       = (state == S_CKE);
    strobe.issuePre    = (state == S_PRE);
    strobe.issueRef    = (state == S_REF) || (state == S_AUTOREF);
    strobe.issueMode   = (state == S_MODE);
    strobe.loadRefresh = ((state == S_WMRD) && timerLast) || (state == S_AUTOREF);
  end

  assign busy  = (state != S_IDLE) && (state != S_READY);
  assign ready = (state == S_READY) || (state == S_AUTOREF) || (state == S_WRUN);
endmodule

// File: rtl/sdram_seq_datapath.sv
module sdram_seq_datapath
  import sdram_seq_pkg::*;
#(
  parameter int ROW_BITS          = 12,
  parameter int BURST_LEN         = 2,
  parameter int CAS_LAT           = 3,
  parameter int BURST_INTERLEAVED = 0,
  parameter int WRITE_SINGLE      = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  output logic                cke,
  output sdCmd_e              cmd,
  output logic                cmdStrobe,
  output logic [ROW_BITS-1:0] addr
);
  localparam int ALL_BANKS_BIT = 10;
  localparam int BL_CODE       = $clog2(BURST_LEN);
  localparam logic [9:0] MODE_LOW = {WRITE_SINGLE[0], 2'b00, CAS_LAT[2:0],
                                     BURST_INTERLEAVED[0], 3'(BL_CODE)};
  localparam logic [ROW_BITS-1:0] MODE_WORD = ROW_BITS'(MODE_LOW);
  localparam logic [ROW_BITS-1:0] PRE_WORD  = ROW_BITS'(1) << ALL_BANKS_BIT;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cke       <= 1'b0;
      cmd       <= CMD_NOP;
      cmdStrobe <= 1'b0;
      addr      <= '0;
    end else begin
      cke       <= cke | strobe.ckeOn;
      cmdStrobe <= strobe.issuePre | strobe.issueRef | strobe.issueMode;
      if (strobe.issuePre) begin
        cmd  <= CMD_PRE;
        addr <= PRE_WORD;
      end else if (strobe.issueRef) begin
        cmd  <= CMD_REF;
        addr <= '0;
      end else if (strobe.issueMode) begin
        cmd  <= CMD_MODE;
        addr <= MODE_WORD;
      end else begin
        cmd  <= CMD_NOP;
        addr <= '0;
      end
    end
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_seq_pkg::*;
#(
  parameter int PWRUP_CYCLES   = 100,
  parameter int T_RP           = 2,
  parameter int T_RC           = 7,
  parameter int T_MRD          = 2,
  parameter int INIT_REFRESHES = 4,
  parameter int REFRESH_RELOAD = 683,
  parameter int ROW_BITS       = 12,
  parameter int BANK_BITS      = 2,
  parameter int DATA_BITS      = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  output logic                 busy,
  output logic                 ready,
  output logic                 cmdStrobe,
  output logic                 sdCke,
  output logic                 sdCsN,
  output logic                 sdRasN,
  output logic                 sdCasN,
  output logic                 sdWeN,
  output logic [BANK_BITS-1:0] sdBa,
  output logic [ROW_BITS-1:0]  sdAddr,
  output logic [DATA_BITS/8-1:0] sdDqm
);
  seqStrobe_t strobe;
  sdCmd_e     cmd;
  logic       refDue;

  sdram_seq_ctrl #(
    .PWRUP_CYCLES(PWRUP_CYCLES), .T_RP(T_RP), .T_RC(T_RC),
    .T_MRD(T_MRD), .INIT_REFRESHES(INIT_REFRESHES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .refDue(refDue),
    .strobe(strobe), .busy(busy), .ready(ready)
  );

  sdram_seq_datapath #(.ROW_BITS(ROW_BITS)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cke(sdCke),
    .cmd(cmd), .cmdStrobe(cmdStrobe), .addr(sdAddr)
  );

  sdram_refresh_timer #(.REFRESH_RELOAD(REFRESH_RELOAD)) i_refTimer (
    .clk(clk), .rstN(rstN), .load(strobe.loadRefresh), .due(refDue)
  );

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = cmd;
  assign sdBa  = '0;
  assign sdDqm = '1;
endmodule

// File: rtl/sdram_init_seq_checker.sv
module sdram_init_seq_checker #(
  parameter int ROW_BITS  = 12,
  parameter int BANK_BITS = 2,
  parameter int DQM_W     = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busy,
  input logic                 ready,
  input logic                 cmdStrobe,
  input logic                 sdCke,
  input logic                 sdCsN,
  input logic                 sdRasN,
  input logic                 sdCasN,
  input logic                 sdWeN,
  input logic [BANK_BITS-1:0] sdBa,
  input logic [ROW_BITS-1:0]  sdAddr,
  input logic [DQM_W-1:0]     sdDqm
);
  logic [3:0] code;
  assign code = {sdCsN, sdRasN, sdCasN, sdWeN};

  p_cke_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(sdCke) |-> sdCke);

  p_no_cmd_without_cke_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |-> sdCke);

  p_precharge_all_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStrobe && code == 4'b0010) |-> sdAddr[10]);

  p_mode_word_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStrobe && code == 4'b0000) |-> (sdAddr == ROW_BITS'(12'h231)));

  p_nop_between_r6: assert property (@(posedge clk) disable iff (!rstN)
    !cmdStrobe |-> (code == 4'b0111));

  p_legal_code_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |-> (code == 4'b0010 || code == 4'b0001 || code == 4'b0000));

  p_ready_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(ready) |-> ready);

  p_refresh_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStrobe && ready) |-> busy);

  p_fixed_pins_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sdBa == '0) && (sdDqm == '1));
endmodule

bind sdram_init_seq sdram_init_seq_checker #(
  .ROW_BITS(ROW_BITS), .BANK_BITS(BANK_BITS), .DQM_W(DATA_BITS/8)
) i_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .ready(ready), .cmdStrobe(cmdStrobe),
  .sdCke(sdCke), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
  .sdBa(sdBa), .sdAddr(sdAddr), .sdDqm(sdDqm)
);

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;
  localparam int PWRUP  = 100;
  localparam int TRP    = 2;
  localparam int TRC    = 7;
  localparam int TMRD   = 2;
  localparam int RELOAD = 683;
  localparam int NCMD   = 9;

  // expected command, address and gap to the previous event
  localparam logic [3:0]  EXP_CMD  [NCMD] = '{4'b0010, 4'b0001, 4'b0001, 4'b0001,
                                              4'b0001, 4'b0000, 4'b0001, 4'b0001, 4'b0001};
  localparam logic [11:0] EXP_ADDR [NCMD] = '{12'h400, 12'h000, 12'h000, 12'h000,
                                              12'h000, 12'h231, 12'h000, 12'h000, 12'h000};
  localparam int          EXP_GAP  [NCMD] = '{PWRUP + 1, TRP, TRC, TRC, TRC, TRC,
                                              RELOAD + TMRD + 1, RELOAD + 2, RELOAD + 2};
  localparam string       EXP_REQ  [NCMD] = '{"R3", "R4", "R4", "R4", "R4", "R5",
                                              "R8", "R8", "R8"};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic busy, ready, cmdStrobe, sdCke, sdCsN, sdRasN, sdCasN, sdWeN;
  logic [1:0]  sdBa;
  logic [11:0] sdAddr;
  logic [1:0]  sdDqm;

  int cyc = 0;
  int nChecks = 0;
  int nFail = 0;
  int nopBad = 0;
  int lastCyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_init_seq #(
    .PWRUP_CYCLES(PWRUP), .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD), .REFRESH_RELOAD(RELOAD)
  ) i_sdram_init_seq (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .ready(ready),
    .cmdStrobe(cmdStrobe), .sdCke(sdCke), .sdCsN(sdCsN), .sdRasN(sdRasN),
    .sdCasN(sdCasN), .sdWeN(sdWeN), .sdBa(sdBa), .sdAddr(sdAddr), .sdDqm(sdDqm)
  );

  function automatic logic [3:0] code();
    return {sdCsN, sdRasN, sdCasN, sdWeN};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R6 monitor: NOP on every cycle without a strobe
  always @(negedge clk) begin
    if (rstN && !cmdStrobe && code() != 4'b0111) nopBad++;
    if (rstN && cmdStrobe && code() == 4'b0111) nopBad++;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(sdCke == 1'b0, "R1", "cke in reset", sdCke, 0);
    check(code() == 4'b0111, "R1", "cmd in reset", code(), 7);
    check(!busy && !ready && !cmdStrobe, "R1", "status in reset", {busy, ready, cmdStrobe}, 0);
    check(sdBa == 2'b00 && sdDqm == 2'b11, "R1", "ba/dqm", {sdBa, sdDqm}, 3);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(!sdCke && !busy, "R1", "idle without start", {sdCke, busy}, 0);

    // R2 start
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2", "busy after start", busy, 1);
    check(sdCke == 1'b0, "R2", "cke one cycle later", sdCke, 0);
    @(negedge clk);
    check(sdCke == 1'b1, "R2", "cke rise", sdCke, 1);
    lastCyc = cyc;
    // R10 restart attempt during power-up wait
    repeat (10) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;

    for (int i = 0; i < NCMD; i++) begin
      @(negedge clk);
      while (!cmdStrobe) @(negedge clk);
      check(code() == EXP_CMD[i], EXP_REQ[i], "command code", code(), EXP_CMD[i]);
      check(sdAddr == EXP_ADDR[i], EXP_REQ[i], "address", sdAddr, EXP_ADDR[i]);
      check(cyc - lastCyc == EXP_GAP[i], EXP_REQ[i], "gap (R4/R10)", cyc - lastCyc, EXP_GAP[i]);
      lastCyc = cyc;
      if (i == 0) begin
        // R10 second restart attempt mid-sequence
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      if (i == 5) begin
        check(ready == 1'b0, "R7", "ready at mode load", ready, 0);
        repeat (TMRD - 1) @(negedge clk);
        check(ready == 1'b1, "R7", "ready after tMRD", ready, 1);
        check(busy == 1'b0, "R7", "busy after tMRD", busy, 0);
        // R10 start after ready
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      if (i >= 6) begin
        check(busy == 1'b1, "R9", "busy at refresh", busy, 1);
        repeat (TRC - 2) @(negedge clk);
        check(busy == 1'b1, "R9", "busy last cycle", busy, 1);
        @(negedge clk);
        check(busy == 1'b0, "R9", "busy released", busy, 0);
        check(ready == 1'b1, "R7", "ready sticky", ready, 1);
      end
    end
    check(nopBad == 0, "R6", "non-NOP without strobe", nopBad, 0);
    check(sdCke == 1'b1, "R2", "cke held", sdCke, 1);

    // reset mid-operation returns to R1 state
    rstN = 1'b0;
    @(negedge clk);
    check(!sdCke && !ready && !busy, "R1", "reset again", {sdCke, ready, busy}, 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    check(!cmdStrobe && !sdCke, "R1", "idle after reset", {cmdStrobe, sdCke}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule